// File: doc/BRIEF.md
# ROM Page Select Latch

This block sits on an 8-bit CPU bus with separate memory and I/O strobes and chooses which quarter of a large ROM is seen in the lowest address window. A four-page ROM of 64 KB is laid over CPU addresses 0x0000 to 0x3FFF. Software changes the page by writing to an I/O port that has address bit 7 low. Port 0x7F is the usual choice. The low data bits of that write are held in a small page register.

The block samples the active-low bus strobes on a system clock. It loads the page register on a qualified I/O write and ignores interrupt-acknowledge cycles, where the I/O strobe and the opcode-fetch strobe are low together. It also produces registered ROM address, chip-enable and output-enable signals for memory cycles. All outputs are registered and lag the bus by one clock. The page register and every output return to a safe state on a synchronous active-high reset, so the system always starts from page 0.

Top module: `rom_page_latch`

## Requirements
- R1: While `rst` is high at a clock edge, the page register is cleared to 0, and after that edge `rom_addr` is 0 and both `rom_ce_n` and `rom_oe_n` are 1.
- R2: At a clock edge where `addr[7]`=0, `iorq_n`=0, `wr_n`=0 and `m1_n`=1, the page register loads `data[1:0]`. Page values 0 to 3 select ROM pages 0 to 3.
- R3: An I/O write with `addr[7]`=1 leaves the page register unchanged.
- R4: A cycle with `iorq_n`=0 and `m1_n`=0 (interrupt acknowledge) leaves the page register unchanged, even when `wr_n` is low and `addr[7]` is 0.
- R5: An I/O read (`rd_n`=0, `wr_n`=1) and a memory write (`mreq_n`=0, `iorq_n`=1) leave the page register unchanged.
- R6: One clock after a bus sample, `rom_addr[15:14]` equals the page register value from before that edge, and `rom_addr[13:0]` equals the sampled `addr[13:0]`.
- R7: One clock after a bus sample, `rom_ce_n` is 0 only if that sample had `mreq_n`=0 and `addr[15:14]`=00.
- R8: `rom_oe_n` is 0 only if `rom_ce_n` is 0, the sample had `rd_n`=0 and the sample had `wr_n`=1.
- R9: A write to port 0x7F selects the page from `data[1:0]` alone, so data 0xFE selects page 2.
- R10: When a ROM read and a page write fall on the same edge, that read is addressed with the old page, and the next read uses the new page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | CPU address bus |
| data | input | 8 | CPU data bus (write data) |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| rom_addr | output | 16 | Registered ROM address: page bits over CPU A13:A0 |
| rom_ce_n | output | 1 | Registered ROM chip enable, active low |
| rom_oe_n | output | 1 | Registered ROM output enable, active low |

## Verification
The two functions that can land on one clock edge are the page register load and the registration of a ROM access at an address that also qualifies as the select port. The bench drives address 0x007F with the memory and I/O strobes and both read and write low together, and gives new page data. It then checks that the registered ROM address still carries the old page and that the output enable stays off because a write was present. A plain read on the following cycle must show the new page.

// File: rtl/rom_page_pkg.sv
package rom_page_pkg;

  // Active-low bus strobes as sampled from the CPU side.
  typedef struct packed {
    logic mreq_n;
    logic iorq_n;
    logic rd_n;
    logic wr_n;
    logic m1_n;
  } bus_strobe_t;

  localparam bus_strobe_t STROBE_IDLE = '{
    mreq_n: 1'b1, iorq_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, m1_n: 1'b1
  };

endpackage

// File: rtl/port_write_decode.sv
module port_write_decode
  import rom_page_pkg::*;
(
  input  logic        sel_bit,
  input  bus_strobe_t strobe,
  output logic        load_en
);

  // Qualified I/O write: select bit low, I/O request and write low,
  // and not an interrupt-acknowledge (m1_n low together with iorq_n).
  always_comb begin
    load_en = ~sel_bit & ~strobe.iorq_n & ~strobe.wr_n & strobe.m1_n;
  end

endmodule

// File: rtl/page_register.sv
module page_register #(
  parameter int PAGE_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_en,
  input  logic [PAGE_BITS-1:0] din,
  output logic [PAGE_BITS-1:0] page
);

  always_ff @(posedge clk) begin
    if (rst)
      page <= '0;
    else if (load_en)
      page <= din;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> page == '0);

  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> page == $past(din));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(page));

endmodule

// File: rtl/rom_port_drive.sv
module rom_port_drive
  import rom_page_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  bus_strobe_t          strobe,
  input  logic [PAGE_BITS-1:0] page,
  output logic [ADDR_W-1:0]    rom_addr,
  output logic                 rom_ce_n,
  output logic                 rom_oe_n
);

  localparam int WIN_BITS = ADDR_W - PAGE_BITS;

  logic in_window;
  logic ce_next;
  logic oe_next;

  always_comb begin
    in_window = (addr[ADDR_W-1:WIN_BITS] == '0);
    ce_next   = ~strobe.mreq_n & in_window;
    oe_next   = ce_next & ~strobe.rd_n & strobe.wr_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      rom_ce_n <= 1'b1;
      rom_oe_n <= 1'b1;
    end else begin
      rom_addr <= {page, addr[WIN_BITS-1:0]};
      rom_ce_n <= ~ce_next;
      rom_oe_n <= ~oe_next;
    end
  end

  assert_outputs_idle_R1: assert property (@(posedge clk)
    rst |=> (rom_ce_n && rom_oe_n && rom_addr == '0));

  assert_low_bits_pass_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rom_addr[WIN_BITS-1:0] == $past(addr[WIN_BITS-1:0]));

  assert_ce_in_window_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe.mreq_n || !in_window) |=> rom_ce_n);

  assert_oe_needs_ce_R8: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_ce_n);

  assert_oe_off_on_write_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.wr_n |=> rom_oe_n);

endmodule

// File: rtl/rom_page_latch.sv
module rom_page_latch
  import rom_page_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 2,
  parameter int SEL_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n
);

  bus_strobe_t          strobe;
  logic                 load_en;
  logic [PAGE_BITS-1:0] page;

  always_comb begin
    strobe.mreq_n = mreq_n;
    strobe.iorq_n = iorq_n;
    strobe.rd_n   = rd_n;
    strobe.wr_n   = wr_n;
    strobe.m1_n   = m1_n;
  end

  port_write_decode u_decode (
    .sel_bit (addr[SEL_BIT]),
    .strobe  (strobe),
    .load_en (load_en)
  );

  page_register #(.PAGE_BITS(PAGE_BITS)) u_page (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .din     (data[PAGE_BITS-1:0]),
    .page    (page)
  );

  rom_port_drive #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .strobe   (strobe),
    .page     (page),
    .rom_addr (rom_addr),
    .rom_ce_n (rom_ce_n),
    .rom_oe_n (rom_oe_n)
  );

  assert_inta_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!iorq_n && !m1_n) |=> $stable(page));

  assert_io_read_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    wr_n |=> $stable(page));

  assert_high_port_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    addr[SEL_BIT] |=> $stable(page));

  assert_page_on_rom_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rom_addr[ADDR_W-1:ADDR_W-PAGE_BITS] == $past(page));

endmodule

// File: tb/rom_page_latch_tb.sv
module rom_page_latch_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [15:0] rom_addr;
  logic        rom_ce_n, rom_oe_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_page_latch u_dut (
    .clk(clk), .rst(rst), .addr(addr), .data(data),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    addr = 16'h0000; data = 8'h00;
    mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
  endtask

  // Drive one bus sample at the falling edge, let one rising edge take it,
  // return to idle at the next falling edge.
  task automatic cycle(input logic [15:0] a, input logic [7:0] d,
                       input logic mq, input logic io, input logic rd,
                       input logic wr, input logic m1);
    @(negedge clk);
    addr = a; data = d; mreq_n = mq; iorq_n = io; rd_n = rd; wr_n = wr; m1_n = m1;
    @(negedge clk);
    idle();
  endtask

  task automatic io_write(input logic [15:0] port, input logic [7:0] d);
    cycle(port, d, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  // Memory read; outputs registered at the edge inside cycle, sampled at its end.
  task automatic mem_read(input logic [15:0] a);
    cycle(a, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic expect_page(input logic [1:0] pg, input string tag);
    mem_read(16'h0123);
    check(rom_addr == {pg, 14'h0123}, tag, rom_addr, {pg, 14'h0123});
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check(rom_addr == 16'h0000, "R1 rom_addr", rom_addr, 16'h0000);
    check(rom_ce_n == 1'b1, "R1 ce_n", {15'd0, rom_ce_n}, 16'd1);
    check(rom_oe_n == 1'b1, "R1 oe_n", {15'd0, rom_oe_n}, 16'd1);
    rst = 1'b0;
    expect_page(2'd0, "R1 boot page");
  endtask

  task automatic t_all_pages();
    for (int p = 0; p < 4; p++) begin
      io_write(16'h0000, 8'(p));
      expect_page(2'(p), "R2 page load");
    end
  endtask

  task automatic t_port_7f();
    io_write(16'h007F, 8'hFE);
    expect_page(2'd2, "R9 port 0x7F data 0xFE");
  endtask

  task automatic t_ignored();
    io_write(16'h00FF, 8'h01);
    expect_page(2'd2, "R3 A7 high ignored");
    cycle(16'h007F, 8'h03, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_page(2'd2, "R4 acknowledge ignored");
    cycle(16'h007F, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_page(2'd2, "R5 io read ignored");
    cycle(16'h007F, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    expect_page(2'd2, "R5 memory write ignored");
  endtask

  task automatic t_rom_signals();
    io_write(16'h007F, 8'h01);
    mem_read(16'h3ABC);
    check(rom_addr == 16'h7ABC, "R6 address merge", rom_addr, 16'h7ABC);
    check(rom_ce_n == 1'b0, "R7 ce in window", {15'd0, rom_ce_n}, 16'd0);
    check(rom_oe_n == 1'b0, "R8 oe on read", {15'd0, rom_oe_n}, 16'd0);
    mem_read(16'h4000);
    check(rom_ce_n == 1'b1, "R7 ce above window", {15'd0, rom_ce_n}, 16'd1);
    check(rom_oe_n == 1'b1, "R8 oe without ce", {15'd0, rom_oe_n}, 16'd1);
    cycle(16'h1000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check(rom_ce_n == 1'b1, "R7 ce needs mreq", {15'd0, rom_ce_n}, 16'd1);
    cycle(16'h1000, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    check(rom_ce_n == 1'b0, "R7 ce on refresh-like access", {15'd0, rom_ce_n}, 16'd0);
    check(rom_oe_n == 1'b1, "R8 oe needs rd", {15'd0, rom_oe_n}, 16'd1);
  endtask

  task automatic t_same_edge();
    // page currently 1; ROM access and page write (to 3) on one edge.
    cycle(16'h007F, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check(rom_addr == 16'h407F, "R10 old page on shared edge", rom_addr, 16'h407F);
    check(rom_oe_n == 1'b1, "R8 oe off during write", {15'd0, rom_oe_n}, 16'd1);
    expect_page(2'd3, "R10 new page next read");
  endtask

  initial begin
    idle();
    t_reset();
    t_all_pages();
    t_port_7f();
    t_ignored();
    t_rom_signals();
    t_same_edge();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule